// File: doc/BRIEF.md
# Triggered Downlink Pattern Player

The block produces one 48-bit downlink word on every clock, aimed at a group of front-end chips. When nothing is happening, it sends a programmable idle word. A sync sequence or a reset sequence can be requested in three ways: a rising edge on a chosen bit of an incoming trigger word, a manual reset pulse, or the rise of run-enable. The block then holds the matching programmable word for a programmable number of cycles and returns to idle. A sync sequence can also be preceded by a programmable wait.

Configuration arrives as a register-style write strobe with the values beside it. The values first go into a staging copy. They are copied into the active copy only while the block is not busy, so a sequence never mixes old and new settings. The output never shows anything other than the active idle, sync or reset word. It does not show zeros during a rewrite. When a sync request and a reset request arrive together, the reset goes out first.

Top module: `dl_pattern_player`

## Requirements
- R1: After reset the active settings are: idle word all ones, sync word 0x0FF0000FFFFF, reset word 0xFFFFFFF00000, both lengths 32, sync delay 0, sync trigger bit 29, reset trigger bit 30, and start-on-run disabled. The output is the idle word and busy is low.
- R2: A sync sequence shows the active sync word for exactly sync-length consecutive cycles and then the idle word. A length of 0 acts as 1.
- R3: A reset sequence shows the active reset word for exactly reset-length consecutive cycles and then the idle word. A length of 0 acts as 1.
- R4: Let a request be sampled at clock edge t. Busy is high after edge t. A reset word first appears after edge t+1. A sync word first appears after edge t+1+D, where D is the sync delay.
- R5: The trigger word is looked at only in cycles where trig_valid is high. A request fires when the selected bit is 1 and was 0 in the previous valid sample. A bit that stays high fires once. Bits seen while trig_valid is low have no effect.
- R6: A man_rst pulse starts a reset sequence whatever the trigger inputs hold.
- R7: Whenever busy is low, the output equals the active idle word.
- R8: When start-on-run is enabled, a 0-to-1 change of run_en requests a sync. When it is disabled, run_en has no effect.
- R9: cfg_wr captures all cfg_* inputs into a staging copy. The staging copy becomes active at the first clock edge at which busy is low. A sequence already under way keeps using the values it started with.
- R10: If a reset request and a sync request are both waiting, the reset sequence runs first and the sync follows it.
- R11: A request of the same kind as a sequence that is running or waiting is dropped. Busy falls only right after the last cycle of a sync or reset word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_word | input | 32 | Incoming trigger bits |
| trig_valid | input | 1 | trig_word holds a sample this cycle |
| run_en | input | 1 | Run-enable level |
| cfg_idle | input | 48 | Idle word to stage |
| cfg_sync | input | 48 | Sync word to stage |
| cfg_rst | input | 48 | Reset word to stage |
| cfg_sync_len | input | 8 | Sync word cycles to stage |
| cfg_rst_len | input | 8 | Reset word cycles to stage |
| cfg_sync_dly | input | 8 | Sync wait cycles to stage |
| cfg_sync_sel | input | 5 | Sync trigger bit index to stage |
| cfg_rst_sel | input | 5 | Reset trigger bit index to stage |
| cfg_sync_at_start | input | 1 | Start-on-run enable to stage |
| cfg_wr | input | 1 | Capture the cfg_* inputs |
| man_rst | input | 1 | Manual reset request pulse |
| dl_word | output | 48 | Downlink pattern word |
| busy | output | 1 | A request is waiting or a sequence is running |

## Verification
The assertions assume that rst_n is held low from time zero until the first clock edges have passed. They also assume that the trigger-bit selects always point inside the trigger word. The stimulus only programs select values of 3, 29 and 30, and it holds reset over several edges. Lengths and delays are kept small in the random phase, so that sequences finish often and the staging copy is loaded many times. Trigger bits, manual pulses, run-enable changes and configuration writes arrive at random, including while sequences are running.

// File: rtl/dl_pattern_player.sv
module dl_pattern_player #(
  parameter int W      = 48,
  parameter int TRIG_W = 32,
  parameter int LEN_W  = 8,
  parameter int DLY_W  = 8,
  parameter int SEL_W  = $clog2(TRIG_W),
  parameter logic [W-1:0] IDLE_INIT = {W{1'b1}},
  parameter logic [W-1:0] SYNC_INIT = 48'h0FF0000FFFFF,
  parameter logic [W-1:0] RST_INIT  = 48'hFFFFFFF00000,
  parameter int LEN_INIT  = 32,
  parameter int SSEL_INIT = 29,
  parameter int RSEL_INIT = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRIG_W-1:0] trig_word,
  input  logic              trig_valid,
  input  logic              run_en,
  input  logic [W-1:0]      cfg_idle,
  input  logic [W-1:0]      cfg_sync,
  input  logic [W-1:0]      cfg_rst,
  input  logic [LEN_W-1:0]  cfg_sync_len,
  input  logic [LEN_W-1:0]  cfg_rst_len,
  input  logic [DLY_W-1:0]  cfg_sync_dly,
  input  logic [SEL_W-1:0]  cfg_sync_sel,
  input  logic [SEL_W-1:0]  cfg_rst_sel,
  input  logic              cfg_sync_at_start,
  input  logic              cfg_wr,
  input  logic              man_rst,
  output logic [W-1:0]      dl_word,
  output logic              busy
);
  localparam int CNT_W = (LEN_W > DLY_W) ? LEN_W : DLY_W;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_SYNC = 2'd2, ST_RST = 2'd3;

  typedef struct packed {
    logic [W-1:0]     idle;
    logic [W-1:0]     sync;
    logic [W-1:0]     rst;
    logic [LEN_W-1:0] slen;
    logic [LEN_W-1:0] rlen;
    logic [DLY_W-1:0] dly;
    logic [SEL_W-1:0] ssel;
    logic [SEL_W-1:0] rsel;
    logic             sstart;
  } cfg_t;

  localparam cfg_t CFG_INIT = '{idle: IDLE_INIT, sync: SYNC_INIT, rst: RST_INIT,
                                slen: LEN_W'(LEN_INIT), rlen: LEN_W'(LEN_INIT), dly: '0,
                                ssel: SEL_W'(SSEL_INIT), rsel: SEL_W'(RSEL_INIT), sstart: 1'b0};

  cfg_t             stg, act;
  logic [1:0]       state;
  logic [CNT_W-1:0] cnt;
  logic             rst_pend, sync_pend;
  logic             s_lvl, r_lvl, run_q;

  function automatic logic [CNT_W-1:0] len_m1(input logic [LEN_W-1:0] l);
    return (l == '0) ? '0 : CNT_W'(l - 1'b1);
  endfunction

  wire s_bit    = trig_word[act.ssel];
  wire r_bit    = trig_word[act.rsel];
  wire sync_req = (trig_valid & s_bit & ~s_lvl) | (act.sstart & run_en & ~run_q);
  wire rst_req  = (trig_valid & r_bit & ~r_lvl) | man_rst;
  wire sync_act = sync_pend | (state == ST_WAIT) | (state == ST_SYNC);
  wire rst_act  = rst_pend | (state == ST_RST);

  assign busy    = rst_pend | sync_pend | (state != ST_IDLE);
  assign dl_word = (state == ST_SYNC) ? act.sync :
                   (state == ST_RST)  ? act.rst  : act.idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= CFG_INIT;
      act <= CFG_INIT;
    end else begin
      if (!busy)
        act <= stg;
      if (cfg_wr)
        stg <= '{idle: cfg_idle, sync: cfg_sync, rst: cfg_rst, slen: cfg_sync_len,
                 rlen: cfg_rst_len, dly: cfg_sync_dly, ssel: cfg_sync_sel,
                 rsel: cfg_rst_sel, sstart: cfg_sync_at_start};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_lvl <= 1'b0;
      r_lvl <= 1'b0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_en;
      if (trig_valid) begin
        s_lvl <= s_bit;
        r_lvl <= r_bit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rst_pend  <= 1'b0;
      sync_pend <= 1'b0;
    end else begin
      if (rst_req && !rst_act)
        rst_pend <= 1'b1;
      if (sync_req && !sync_act)
        sync_pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (rst_pend) begin
            rst_pend <= 1'b0;
            state    <= ST_RST;
            cnt      <= len_m1(act.rlen);
          end else if (sync_pend) begin
            sync_pend <= 1'b0;
            if (act.dly == '0) begin
              state <= ST_SYNC;
              cnt   <= len_m1(act.slen);
            end else begin
              state <= ST_WAIT;
              cnt   <= CNT_W'(act.dly - 1'b1);
            end
          end
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            state <= ST_SYNC;
            cnt   <= len_m1(act.slen);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0)
            state <= ST_IDLE;
          else
            cnt <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pattern_player_chk.sv
module pattern_player_chk #(
  parameter int W     = 48,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [W-1:0]     dl_word,
  input logic [1:0]       state,
  input logic             rst_pend,
  input logic             sync_pend,
  input logic [W-1:0]     act_idle,
  input logic [W-1:0]     act_sync,
  input logic [W-1:0]     act_rst,
  input logic [LEN_W-1:0] act_slen,
  input logic [LEN_W-1:0] act_rlen
);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_SYNC = 2'd2, ST_RST = 2'd3;

  logic [LEN_W:0] s_run, r_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_run <= '0;
      r_run <= '0;
    end else begin
      s_run <= (state == ST_SYNC) ? s_run + 1'b1 : '0;
      r_run <= (state == ST_RST)  ? r_run + 1'b1 : '0;
    end
  end

  // R7
  idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dl_word == act_idle);

  // R9
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(act_sync) && $stable(act_rst) &&
                               $stable(act_slen) && $stable(act_rlen)));

  // R2
  sync_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_SYNC && state != ST_SYNC) |->
      s_run == ((act_slen == '0) ? (LEN_W+1)'(1) : {1'b0, act_slen}));

  // R3
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_RST && state != ST_RST) |->
      r_run == ((act_rlen == '0) ? (LEN_W+1)'(1) : {1'b0, act_rlen}));

  // R10
  rst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && rst_pend && sync_pend) |=> state == ST_RST);

  // R11
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(state) == ST_SYNC || $past(state) == ST_RST));
endmodule

bind dl_pattern_player pattern_player_chk #(.W(W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dl_word(dl_word), .state(state),
  .rst_pend(rst_pend), .sync_pend(sync_pend), .act_idle(act.idle),
  .act_sync(act.sync), .act_rst(act.rst), .act_slen(act.slen), .act_rlen(act.rlen));

// File: tb/test_dl_pattern_player.sv
`timescale 1ns/1ps
module test_dl_pattern_player;
  typedef struct packed {
    logic [47:0] idle, sync, rst;
    logic [7:0]  slen, rlen, dly;
    logic [4:0]  ssel, rsel;
    logic        sstart;
  } mcfg_t;

  localparam mcfg_t M_INIT = '{idle: {48{1'b1}}, sync: 48'h0FF0000FFFFF, rst: 48'hFFFFFFF00000,
                               slen: 8'd32, rlen: 8'd32, dly: 8'd0, ssel: 5'd29, rsel: 5'd30,
                               sstart: 1'b0};

  logic clk = 0, rst_n = 0;
  logic [31:0] trig_word = '0;
  logic trig_valid = 0, run_en = 0, cfg_wr = 0, man_rst = 0;
  mcfg_t cfg = M_INIT;
  logic [47:0] dl_word;
  logic busy;

  always #2 clk = ~clk;

  dl_pattern_player i_dl_pattern_player (
    .clk(clk), .rst_n(rst_n), .trig_word(trig_word), .trig_valid(trig_valid), .run_en(run_en),
    .cfg_idle(cfg.idle), .cfg_sync(cfg.sync), .cfg_rst(cfg.rst), .cfg_sync_len(cfg.slen),
    .cfg_rst_len(cfg.rlen), .cfg_sync_dly(cfg.dly), .cfg_sync_sel(cfg.ssel),
    .cfg_rst_sel(cfg.rsel), .cfg_sync_at_start(cfg.sstart), .cfg_wr(cfg_wr),
    .man_rst(man_rst), .dl_word(dl_word), .busy(busy));

  int tests = 0, fails = 0;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // reference model of the requirements
  mcfg_t m_act, m_stg;
  int m_st, m_cnt;
  bit m_rp, m_sp, m_sl, m_rl, m_rq, m_on;
  bit mb, msb, mrb, msr, mrr, mrbusy, msbusy, o_rp, o_sp;

  function automatic int lm1(logic [7:0] l);
    return (l == 0) ? 0 : int'(l) - 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = M_INIT; m_stg = M_INIT; m_st = 0; m_cnt = 0;
      m_rp = 0; m_sp = 0; m_sl = 0; m_rl = 0; m_rq = 0;
    end else begin
      mb = m_rp || m_sp || m_st != 0;
      msb = trig_word[m_act.ssel]; mrb = trig_word[m_act.rsel];
      msr = (trig_valid && msb && !m_sl) || (m_act.sstart && run_en && !m_rq);
      mrr = (trig_valid && mrb && !m_rl) || man_rst;
      mrbusy = m_rp || m_st == 3; msbusy = m_sp || m_st == 1 || m_st == 2;
      o_rp = m_rp; o_sp = m_sp;
      if (trig_valid) begin m_sl = msb; m_rl = mrb; end
      m_rq = run_en;
      case (m_st)
        0: if (o_rp) begin m_st = 3; m_cnt = lm1(m_act.rlen); m_rp = 0; end
           else if (o_sp) begin
             m_sp = 0;
             if (m_act.dly == 0) begin m_st = 2; m_cnt = lm1(m_act.slen); end
             else begin m_st = 1; m_cnt = int'(m_act.dly) - 1; end
           end
        1: if (m_cnt == 0) begin m_st = 2; m_cnt = lm1(m_act.slen); end else m_cnt--;
        default: if (m_cnt == 0) m_st = 0; else m_cnt--;
      endcase
      if (mrr && !mrbusy) m_rp = 1;
      if (msr && !msbusy) m_sp = 1;
      if (!mb) m_act = m_stg;
      if (cfg_wr) m_stg = cfg;
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_on) begin
      string tg;
      logic [47:0] ew;
      tg = (m_st == 2) ? "R2" : (m_st == 3) ? "R3" : (m_st == 1) ? "R4" : "R7";
      ew = (m_st == 2) ? m_act.sync : (m_st == 3) ? m_act.rst : m_act.idle;
      chk({tg, " model word"}, 64'(dl_word), 64'(ew));
      chk("R11 model busy", 64'(busy), 64'(m_rp || m_sp || m_st != 0));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg();
    cfg_wr = 1; @(negedge clk); cfg_wr = 0; cyc(3);
  endtask

  task automatic watch(string tag, logic [47:0] pat, int first, int len, int n);
    int badk = 0;
    logic [47:0] badw = '0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k == 1) begin
        trig_word = '0; man_rst = 0; cfg_wr = 0;
        if (!busy && badk == 0) begin badk = k; badw = dl_word; end
      end
      if (k == 2) trig_valid = 0;
      if (((dl_word == pat) != (k >= first && k < first + len)) && badk == 0) begin
        badk = k; badw = dl_word;
      end
    end
    chk({tag, " window"}, 64'(badk), 64'(0));
    if (badk != 0) $display("  cycle %0d word %0h", badk, badw);
  endtask

  task automatic count_words(int n, logic [47:0] pat, output int c);
    c = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k == 1) begin man_rst = 0; cfg_wr = 0; trig_word = '0; end
      if (k == 2) trig_valid = 0;
      if (dl_word == pat) c++;
    end
  endtask

  task automatic fire(logic [31:0] w, bit man);
    trig_valid = 1; trig_word = w; man_rst = man;
  endtask

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c;
    logic [47:0] old_rst;
    cyc(4);
    rst_n = 1; m_on = 1;
    cyc(1);
    chk("R1 idle after reset", 64'(dl_word), 64'({48{1'b1}}));
    chk("R1 busy after reset", 64'(busy), 64'(0));

    // default reset via bit 30, default sync via bit 29
    fire(32'h4000_0000, 0); watch("R3 R4 default reset", 48'hFFFFFFF00000, 2, 32, 36);
    chk("R11 busy low after reset seq", 64'(busy), 64'(0));
    fire(32'h2000_0000, 0); watch("R2 default sync", 48'h0FF0000FFFFF, 2, 32, 36);

    cfg = '{idle: 48'hC3C33C3CA5A5, sync: 48'h123456789ABC, rst: 48'hFEDCBA987654,
            slen: 8'd5, rlen: 8'd4, dly: 8'd3, ssel: 5'd29, rsel: 5'd30, sstart: 1'b0};
    write_cfg();
    chk("R9 new idle active", 64'(dl_word), 64'(48'hC3C33C3CA5A5));
    fire(32'h2000_0000, 0); watch("R4 delayed sync", cfg.sync, 5, 5, 14);
    fire(32'h4000_0000, 0); watch("R3 short reset", cfg.rst, 2, 4, 8);
    fire(32'h1234_5678 & 32'h9FFF_FFFF, 1); watch("R6 manual reset", cfg.rst, 2, 4, 8);

    fire(32'h6000_0000, 0);
    watch("R10 reset first", cfg.rst, 2, 4, 6);
    watch("R10 sync after reset", cfg.sync, 4, 5, 10);

    trig_valid = 1; trig_word = 32'h4000_0000;
    cyc(1);
    c = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (dl_word == cfg.rst) c++; end
    chk("R5 held bit fires once", 64'(c), 64'(4));
    trig_word = '0; cyc(1); trig_valid = 0;
    trig_word = 32'h4000_0000; cyc(1); trig_word = '0; cyc(1); trig_word = 32'h4000_0000;
    count_words(10, cfg.rst, c);
    chk("R5 invalid samples ignored", 64'(c), 64'(0));

    man_rst = 1; cyc(1); man_rst = 0; cyc(1); man_rst = 1;
    count_words(12, cfg.rst, c);
    chk("R11 duplicate reset ignored", 64'(c), 64'(3));

    cfg.rlen = 8'd6; write_cfg();
    old_rst = cfg.rst;
    man_rst = 1; cyc(1); man_rst = 0; cyc(1);
    cfg.rst = 48'h0A0B0C0D0E0F; cfg.rlen = 8'd2; cfg_wr = 1;
    count_words(10, old_rst, c);
    chk("R9 running seq keeps old cfg", 64'(c), 64'(5));
    cyc(2);
    man_rst = 1; count_words(8, cfg.rst, c);
    chk("R9 staged cfg used next", 64'(c), 64'(2));

    run_en = 1; count_words(15, cfg.sync, c);
    chk("R8 run start disabled", 64'(c), 64'(0));
    run_en = 0; cfg.sstart = 1; write_cfg();
    run_en = 1; count_words(15, cfg.sync, c);
    chk("R8 run start enabled", 64'(c), 64'(5));

    cfg.rlen = 8'd0; cfg.sstart = 0; write_cfg();
    man_rst = 1; count_words(8, cfg.rst, c);
    chk("R3 zero length acts as one", 64'(c), 64'(1));

    // random phase, checked by the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      trig_valid = $urandom % 2;
      trig_word = $urandom & 32'h9FFF_FFFF;
      if ($urandom % 8 == 0) trig_word[29] = 1;
      if ($urandom % 8 == 0) trig_word[30] = 1;
      man_rst = ($urandom % 40 == 0);
      if ($urandom % 50 == 0) run_en = ~run_en;
      cfg_wr = ($urandom % 60 == 0);
      if (cfg_wr) begin
        logic [4:0] sels [3];
        sels[0] = 5'd29; sels[1] = 5'd30; sels[2] = 5'd3;
        cfg.idle = {16'h8000 | 16'($urandom), 32'($urandom)};
        cfg.sync = {16'h4000 | 16'($urandom), 32'($urandom)};
        cfg.rst  = {16'h2000 | 16'($urandom), 32'($urandom)};
        cfg.slen = 8'($urandom % 7); cfg.rlen = 8'($urandom % 7);
        cfg.dly  = 8'($urandom % 4);
        cfg.ssel = sels[$urandom % 3]; cfg.rsel = sels[$urandom % 3];
        cfg.sstart = 1'($urandom);
      end
    end
    trig_valid = 0; man_rst = 0; cfg_wr = 0;
    cyc(60);
    chk("R7 idle at end", 64'(busy), 64'(0));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule